// File: doc/BRIEF.md
# Phase2-Qualified Memory Strobe Decoder

This block turns the address, read/write and Phase2 signals of an 8-bit microprocessor bus into the enable strobes for a RAM, a ROM and an I/O window. No device can drive or accept data unless Phase2 is high. The address bus settles while Phase2 is low, so all output-enable, write-enable and select strobes stay inactive in that half-cycle.

The RAM fills the whole address space and has two enables. An active-low enable carries the address decode, and an active-high enable follows Phase2. The device is live only when both are true. The I/O window takes priority over everything beneath it. A ROM sits over the top of the space. Writes there always fall through to the RAM. Reads come from the ROM or the RAM depending on a one-bit overlay register, which the CPU writes through the bus at a fixed control address.

The overlay register is sampled in the system clock domain. It captures data bit 0 at the first clock edge that sees Phase2 low after a write cycle to the control address, while that cycle's address, R/W and data are still held.

Top module: `bus_mem_decoder`

## Requirements
- R1: While Phase2 is low, ram_ce1 is 0 and ram_oe_n, ram_we_n, rom_cs_n, rom_oe_n and io_sel_n are all 1.
- R2: ram_ce1 equals phi2 at all times.
- R3: ram_oe_n is 0 exactly when phi2=1, rw=1, the address is outside 0xD000–0xDFFF, and either the address is below 0xE000 or the overlay bit is 1.
- R4: ram_we_n is 0 exactly when phi2=1, rw=0 and the address is outside 0xD000–0xDFFF. This includes 0xE000–0xFFFF, whatever the overlay bit is (write-through).
- R5: ram_ce0_n is 0 exactly when the address is outside 0xD000–0xDFFF and at least one of these holds: rw=0, the address is below 0xE000, or the overlay bit is 1.
- R6: rom_cs_n and rom_oe_n are both 0 exactly when phi2=1, rw=1, the address is in 0xE000–0xFFFF and the overlay bit is 0. They are never 0 on a write.
- R7: io_sel_n is 0 exactly when phi2=1 and the address is in 0xD000–0xDFFF.
- R8: The overlay bit resets to 0. It takes data_in bit 0 after a bus cycle with rw=0 at address 0xD0FF, at the first clock edge that sees phi2 low while that cycle's address, rw and data are still held.
- R9: In every cycle at most one of ram_oe_n, rom_oe_n and io_sel_n is 0.
- R10: A read cycle at 0xD0FF and a write cycle to any other address leave the overlay bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than Phase2 |
| rst_n | input | 1 | Synchronous active-low reset |
| phi2 | input | 1 | Bus Phase2 clock |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 16 | CPU address bus |
| data_in | input | 8 | CPU data bus (bit 0 feeds the overlay register) |
| ram_ce0_n | output | 1 | RAM address-decode enable, active low |
| ram_ce1 | output | 1 | RAM Phase2 enable, active high |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| rom_cs_n | output | 1 | ROM chip select, active low |
| rom_oe_n | output | 1 | ROM output enable, active low |
| io_sel_n | output | 1 | I/O window select, active low |

## Verification
The bench builds the block with its default parameters: a 16-bit address, I/O at 0xD000–0xDFFF, ROM from 0xE000 and the control register at 0xD0FF. All 65,536 addresses can then be swept against both R/W levels and both Phase2 levels, once with the overlay bit clear and once with it set. Every strobe is compared with values computed from the map in every combination, and output-enable exclusivity is checked in each one. Directed bus cycles cover the reset value of the overlay bit, its set and clear, and the read and wrong-address cycles that must not change it.

// File: rtl/bdec_pkg.sv
// Package: shared types for the bus memory-select decoder.
// Assumes a single flat address space split into three kinds of region.
package bdec_pkg;

    // Which device family an address falls into after priority resolution.
    typedef enum logic [1:0] {
        REG_RAM = 2'd0,
        REG_IO  = 2'd1,
        REG_ROM = 2'd2
    } region_t;

endpackage

// File: rtl/bdec_region.sv
// Module: bdec_region
// Classifies an address as RAM, I/O or ROM-overlay. The I/O window has
// priority over the ROM window, and RAM covers everything else. It also
// flags an exact hit on the overlay control address.
// Assumes IO_BASE <= IO_LAST and that the ROM window runs from ROM_BASE
// to the top of the address space.
module bdec_region
    import bdec_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int IO_BASE   = 16'hD000,
    parameter int IO_LAST   = 16'hDFFF,
    parameter int ROM_BASE  = 16'hE000,
    parameter int CTRL_ADDR = 16'hD0FF
) (
    input  logic [ADDR_W-1:0] addr,
    output region_t           region,
    output logic              ctrl_hit
);

    localparam logic [ADDR_W-1:0] IO_LO  = ADDR_W'(IO_BASE);
    localparam logic [ADDR_W-1:0] IO_HI  = ADDR_W'(IO_LAST);
    localparam logic [ADDR_W-1:0] ROM_LO = ADDR_W'(ROM_BASE);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

    // Priority decode: I/O first, then ROM overlay, then RAM.
    always_comb begin
        if (addr >= IO_LO && addr <= IO_HI) begin
            region = REG_IO;
        end else if (addr >= ROM_LO) begin
            region = REG_ROM;
        end else begin
            region = REG_RAM;
        end
    end

    // Exact match on the overlay control register address.
    assign ctrl_hit = (addr == CTRL_A);

endmodule

// File: rtl/bdec_overlay.sv
// Module: bdec_overlay
// Holds the ROM-switched-out bit. It detects the falling edge of Phase2 in
// the system clock domain and, if the finished cycle was a write to the
// control address, loads the data bit.
// Assumes clk is fast enough to see each Phase2 level at least once, and
// that addr, rw and data stay valid until the edge that sees Phase2 low.
module bdec_overlay (
    input  logic clk,
    input  logic rst_n,
    input  logic phi2,
    input  logic rw,
    input  logic ctrl_hit,
    input  logic data_bit,
    output logic overlay_on
);

    logic phi2_q;
    logic wr_commit;

    // Delayed copy of Phase2 for edge detection; sampled even during reset.
    always_ff @(posedge clk) begin
        phi2_q <= phi2;
    end

    // A write cycle to the control address finishes as Phase2 falls.
    assign wr_commit = phi2_q && !phi2 && !rw && ctrl_hit;

    // Overlay bit: cleared by reset so the ROM is visible, loaded on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overlay_on <= 1'b0;
        end else if (wr_commit) begin
            overlay_on <= data_bit;
        end
    end

endmodule

// File: rtl/bdec_strobes.sv
// Module: bdec_strobes
// Combines Phase2, R/W, the decoded region and the overlay bit into the
// device strobes. Every output-enable, write-enable and select is gated by
// Phase2. The RAM decode enable reflects only the address, the direction
// and the overlay bit.
// Assumes the region input has already resolved I/O-over-ROM priority.
module bdec_strobes
    import bdec_pkg::*;
(
    input  logic    phi2,
    input  logic    rw,
    input  region_t region,
    input  logic    overlay_on,
    output logic    ram_ce0_n,
    output logic    ram_ce1,
    output logic    ram_oe_n,
    output logic    ram_we_n,
    output logic    rom_cs_n,
    output logic    rom_oe_n,
    output logic    io_sel_n
);

    logic is_io;
    logic is_rom;
    logic ram_claims;
    logic rom_reads;

    // Region flags.
    always_comb begin
        is_io  = (region == REG_IO);
        is_rom = (region == REG_ROM);
    end

    // RAM owns the cycle unless I/O wins, or a ROM read is not overlaid.
    always_comb begin
        ram_claims = !is_io && (!rw || !is_rom || overlay_on);
        rom_reads  = phi2 && rw && is_rom && !overlay_on;
    end

    // Drive the active-low strobes and the Phase2-following RAM enable.
    always_comb begin
        ram_ce0_n = !ram_claims;
        ram_ce1   = phi2;
        ram_oe_n  = !(phi2 && rw && ram_claims);
        ram_we_n  = !(phi2 && !rw && !is_io);
        rom_cs_n  = !rom_reads;
        rom_oe_n  = !rom_reads;
        io_sel_n  = !(phi2 && is_io);
    end

endmodule

// File: rtl/bus_mem_decoder.sv
// Module: bus_mem_decoder
// Top of the memory-select decoder: address classification, the overlay
// control register and the Phase2-gated strobe generator.
// Assumes a synchronous system clock faster than Phase2 and an active-low
// synchronous reset.
module bus_mem_decoder
    import bdec_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int IO_BASE   = 16'hD000,
    parameter int IO_LAST   = 16'hDFFF,
    parameter int ROM_BASE  = 16'hE000,
    parameter int CTRL_ADDR = 16'hD0FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phi2,
    input  logic              rw,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data_in,
    output logic              ram_ce0_n,
    output logic              ram_ce1,
    output logic              ram_oe_n,
    output logic              ram_we_n,
    output logic              rom_cs_n,
    output logic              rom_oe_n,
    output logic              io_sel_n
);

    region_t region;
    logic    ctrl_hit;
    logic    overlay_on;
    logic    unused_data;

    // Only bit 0 of the data bus reaches the control register.
    assign unused_data = ^data_in[DATA_W-1:1];

    bdec_region #(
        .ADDR_W   (ADDR_W),
        .IO_BASE  (IO_BASE),
        .IO_LAST  (IO_LAST),
        .ROM_BASE (ROM_BASE),
        .CTRL_ADDR(CTRL_ADDR)
    ) u_region (
        .addr    (addr),
        .region  (region),
        .ctrl_hit(ctrl_hit)
    );

    bdec_overlay u_overlay (
        .clk       (clk),
        .rst_n     (rst_n),
        .phi2      (phi2),
        .rw        (rw),
        .ctrl_hit  (ctrl_hit),
        .data_bit  (data_in[0]),
        .overlay_on(overlay_on)
    );

    bdec_strobes u_strobes (
        .phi2      (phi2),
        .rw        (rw),
        .region    (region),
        .overlay_on(overlay_on),
        .ram_ce0_n (ram_ce0_n),
        .ram_ce1   (ram_ce1),
        .ram_oe_n  (ram_oe_n),
        .ram_we_n  (ram_we_n),
        .rom_cs_n  (rom_cs_n),
        .rom_oe_n  (rom_oe_n),
        .io_sel_n  (io_sel_n)
    );

endmodule

// File: rtl/bdec_checker.sv
// Module: bdec_checker
// Temporal properties of the decoder, attached to the top through bind.
module bdec_checker #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int IO_BASE   = 16'hD000,
    parameter int IO_LAST   = 16'hDFFF,
    parameter int ROM_BASE  = 16'hE000,
    parameter int CTRL_ADDR = 16'hD0FF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              phi2,
    input logic              rw,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] data_in,
    input logic              overlay_on,
    input logic              ram_ce1,
    input logic              ram_oe_n,
    input logic              ram_we_n,
    input logic              rom_cs_n,
    input logic              rom_oe_n,
    input logic              io_sel_n
);

    localparam logic [ADDR_W-1:0] IO_LO  = ADDR_W'(IO_BASE);
    localparam logic [ADDR_W-1:0] IO_HI  = ADDR_W'(IO_LAST);
    localparam logic [ADDR_W-1:0] ROM_LO = ADDR_W'(ROM_BASE);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

    assert_quiet_low_phase_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !phi2 |-> (!ram_ce1 && ram_oe_n && ram_we_n && rom_cs_n && rom_oe_n && io_sel_n));

    assert_ram_write_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we_n |-> (phi2 && !rw));

    assert_rom_read_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_oe_n |-> (phi2 && rw && addr >= ROM_LO && !overlay_on && !rom_cs_n));

    assert_io_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !io_sel_n |-> (addr >= IO_LO && addr <= IO_HI));

    assert_overlay_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phi2) && !phi2 && !rw && addr == CTRL_A) |=> (overlay_on == $past(data_in[0])));

    assert_single_driver_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({!ram_oe_n, !rom_oe_n, !io_sel_n}) <= 1);

endmodule

bind bus_mem_decoder bdec_checker #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .IO_BASE  (IO_BASE),
    .IO_LAST  (IO_LAST),
    .ROM_BASE (ROM_BASE),
    .CTRL_ADDR(CTRL_ADDR)
) i_bdec_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .phi2      (phi2),
    .rw        (rw),
    .addr      (addr),
    .data_in   (data_in),
    .overlay_on(overlay_on),
    .ram_ce1   (ram_ce1),
    .ram_oe_n  (ram_oe_n),
    .ram_we_n  (ram_we_n),
    .rom_cs_n  (rom_cs_n),
    .rom_oe_n  (rom_oe_n),
    .io_sel_n  (io_sel_n)
);

// File: tb/test_bus_mem_decoder.sv
`timescale 1ns/1ps
// Bench: exhaustive sweep of address x R/W x Phase2 for both overlay states,
// plus directed bus cycles for the overlay register.
module test_bus_mem_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phi2 = 1'b0;
    logic        rw = 1'b1;
    logic [15:0] addr = 16'h0000;
    logic [7:0]  data_in = 8'h00;
    logic ram_ce0_n, ram_ce1, ram_oe_n, ram_we_n, rom_cs_n, rom_oe_n, io_sel_n;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    bus_mem_decoder i_bus_mem_decoder (
        .clk(clk), .rst_n(rst_n), .phi2(phi2), .rw(rw), .addr(addr),
        .data_in(data_in), .ram_ce0_n(ram_ce0_n), .ram_ce1(ram_ce1),
        .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n), .rom_cs_n(rom_cs_n),
        .rom_oe_n(rom_oe_n), .io_sel_n(io_sel_n)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s addr=%h rw=%0b phi2=%0b actual=%0b expected=%0b",
                     tag, addr, rw, phi2, act, exp);
        end
    endtask

    // Compare every strobe against values computed from the memory map.
    task automatic check_all(input logic ovl);
        logic io, rom, claims;
        io     = (addr >= 16'hD000) && (addr <= 16'hDFFF);
        rom    = (addr >= 16'hE000) && !io;
        claims = !io && (!rw || !rom || ovl);
        chk("R5 ram_ce0_n", ram_ce0_n, !claims);
        chk("R2 ram_ce1",   ram_ce1,   phi2);
        chk("R3 ram_oe_n",  ram_oe_n,  !(phi2 && rw && !io && (!rom || ovl)));
        chk("R4 ram_we_n",  ram_we_n,  !(phi2 && !rw && !io));
        chk("R6 rom_cs_n",  rom_cs_n,  !(phi2 && rw && rom && !ovl));
        chk("R6 rom_oe_n",  rom_oe_n,  !(phi2 && rw && rom && !ovl));
        chk("R7 io_sel_n",  io_sel_n,  !(phi2 && io));
        chk("R9 one_output_enable", ($countones({!ram_oe_n, !rom_oe_n, !io_sel_n}) <= 1), 1'b1);
        if (!phi2)
            chk("R1 quiet_when_phi2_low",
                (!ram_ce1 && ram_oe_n && ram_we_n && rom_cs_n && rom_oe_n && io_sel_n), 1'b1);
    endtask

    // One full bus cycle: set up with Phase2 low, raise it, then drop it.
    task automatic bus_cycle(input logic [15:0] a, input logic r, input logic [7:0] d);
        @(negedge clk);
        addr = a; rw = r; data_in = d; phi2 = 1'b0;
        repeat (2) @(negedge clk);
        phi2 = 1'b1;
        repeat (2) @(negedge clk);
        phi2 = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Probe the visible overlay state with a read at 0xE000 during Phase2 high.
    task automatic probe_overlay(input string tag, input logic exp_ovl);
        @(negedge clk);
        addr = 16'hE000; rw = 1'b1; phi2 = 1'b1;
        @(negedge clk);
        chk(tag, rom_oe_n, exp_ovl);
        chk(tag, ram_oe_n, !exp_ovl);
        phi2 = 1'b0;
        @(negedge clk);
    endtask

    // Full sweep with data bit 0 matching the overlay, so a stray commit is a no-op.
    task automatic sweep(input logic ovl);
        data_in = {7'd0, ovl};
        for (int a = 0; a < 65536; a++) begin
            for (int r = 0; r < 2; r++) begin
                for (int p = 0; p < 2; p++) begin
                    addr = 16'(a); rw = r[0]; phi2 = p[0];
                    #1;
                    check_all(ovl);
                end
            end
        end
        phi2 = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        probe_overlay("R8 reset_value", 1'b0);
        sweep(1'b0);
        bus_cycle(16'hD0FF, 1'b1, 8'h01);
        probe_overlay("R10 read_at_ctrl", 1'b0);
        bus_cycle(16'hD0FE, 1'b0, 8'h01);
        probe_overlay("R10 write_other_addr", 1'b0);
        bus_cycle(16'hD0FF, 1'b0, 8'hFE);
        probe_overlay("R8 uses_bit0_only", 1'b0);
        bus_cycle(16'hD0FF, 1'b0, 8'h01);
        probe_overlay("R8 set_overlay", 1'b1);
        sweep(1'b1);
        bus_cycle(16'hD0FF, 1'b1, 8'h00);
        probe_overlay("R10 read_keeps_set", 1'b1);
        bus_cycle(16'h1234, 1'b0, 8'h00);
        probe_overlay("R10 other_write_keeps_set", 1'b1);
        bus_cycle(16'hD0FF, 1'b0, 8'h00);
        probe_overlay("R8 clear_overlay", 1'b0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: ends a hung run as a failure.
    initial begin
        #(150000 * 20);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule